// File: doc/BRIEF.md
# Sequential Signed Halfword Divider

This block divides a 32-bit two's-complement dividend by a divisor taken from the low 16 bits of a 32-bit operand and sign-extended. It produces a 32-bit quotient that truncates toward zero, plus held zero, sign and overflow flags. Ordinary divisions run as a restoring divider on operand magnitudes. It produces one quotient bit per clock and applies the sign in a final correction cycle. The block does not produce a carry flag, so a carry kept elsewhere is not disturbed.

Requests enter on a valid/ready pair. A request transfers on a rising edge where both `req_valid` and `req_ready` are high. `req_ready` is high only while the divider is idle. A requester may hold `req_valid` and its operands for as long as it likes; nothing is taken until `req_ready` is high. The result side has no back-pressure. `res_valid` is a one-cycle pulse, and the receiver must take `res_quot`, `res_wr` and the flags in that cycle. Outside that pulse the outputs keep their last values. A zero divisor and the "most negative dividend over minus one" case are decided in the accepting cycle and finish at once. Both report overflow.

Top module: `hdiv_top`

## Requirements
- R1: After reset `req_ready` is 1, `res_valid` is 0, and `res_quot`, `res_wr`, `flag_z`, `flag_s` and `flag_ov` are all 0.
- R2: Only `req_divisor[15:0]` is used, read as a signed 16-bit value; bits 31:16 have no effect on any result.
- R3: For a non-zero divisor, excluding the R8 case, `res_quot` equals the signed dividend divided by the signed divisor, truncated toward zero.
- R4: A normal division accepted at edge k gives `res_valid` high in the single cycle after edge k+33. `req_ready` is low from edge k until that cycle.
- R5: A normal division ends with `flag_ov` = 0 and `res_wr` = 1, including 0x80000000 divided by 1.
- R6: Whenever `res_wr` = 1 on completion, `flag_z` is 1 exactly when `res_quot` is 0, and `flag_s` equals `res_quot[31]`.
- R7: A zero low halfword of the divisor completes in the cycle right after the accepting edge, with `flag_ov` = 1 and `res_wr` = 0. `res_quot`, `flag_z` and `flag_s` keep their previous values.
- R8: A dividend of 0x80000000 with a low divisor halfword of 0xFFFF completes in the cycle right after the accepting edge. It gives `res_quot` = 0x80000000, `flag_ov` = 1, `flag_s` = 1, `flag_z` = 0 and `res_wr` = 1.
- R9: `req_valid` asserted while `req_ready` is 0 is not taken. It produces no extra completion and does not change the running result.
- R10: `res_valid` lasts one cycle per accepted request. Between completions, `res_quot`, `res_wr` and all flags hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Divider idle and able to accept |
| req_dividend | input | 32 | Signed dividend |
| req_divisor | input | 32 | Operand whose low 16 bits are the signed divisor |
| res_valid | output | 1 | One-cycle completion pulse |
| res_quot | output | 32 | Quotient, held between completions |
| res_wr | output | 1 | Quotient is to be written back |
| flag_z | output | 1 | Zero flag |
| flag_s | output | 1 | Sign flag |
| flag_ov | output | 1 | Overflow flag |

## Verification
The properties assume that every request is answered before the receiver needs the next result, because the result side cannot stall. They also assume that operands are only meaningful in the cycle they transfer. The stimulus changes inputs only on falling edges. It reads completions in their pulse cycle and deliberately changes operands while the divider is busy, to show those operands are ignored. It releases `req_valid` before the completion cycle except where it means to start a new request.

// File: rtl/hdiv_pkg.sv
package hdiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ITER = 2'd1,
    ST_FIX  = 2'd2
  } hdiv_state_e;
endpackage

// File: rtl/hdiv_prep.sv
// Operand preparation: halfword sign extension, magnitudes, result sign and
// detection of the two cases that finish without iterating.
module hdiv_prep #(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 16
) (
  input  logic [DATA_W-1:0] dividend,
  input  logic [DIV_W-1:0]  divisor_lo,
  output logic [DATA_W-1:0] dd_mag,
  output logic [DIV_W-1:0]  dv_mag,
  output logic              q_neg,
  output logic              dv_zero,
  output logic              min_by_m1
);
  localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  logic dd_sign, dv_sign;

  always_comb begin
    dd_sign   = dividend[DATA_W-1];
    dv_sign   = divisor_lo[DIV_W-1];
    dd_mag    = dd_sign ? (~dividend + 1'b1) : dividend;
    dv_mag    = dv_sign ? (~divisor_lo + 1'b1) : divisor_lo;
    q_neg     = dd_sign ^ dv_sign;
    dv_zero   = (divisor_lo == '0);
    min_by_m1 = (dividend == MOST_NEG) && (divisor_lo == '1);
  end
endmodule

// File: rtl/hdiv_iter.sv
// Restoring unsigned divider: one quotient bit per step.
// The quotient register starts as the dividend magnitude and shifts left.
module hdiv_iter #(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [DATA_W-1:0] dd_mag,
  input  logic [DIV_W-1:0]  dv_mag,
  output logic [DATA_W-1:0] q_mag
);
  logic [DIV_W-1:0]  rem_q;
  logic [DIV_W-1:0]  dv_q;
  logic [DATA_W-1:0] quo_q;
  logic [DIV_W:0]    trial;
  logic [DIV_W:0]    diff;
  logic              fits;

  always_comb begin
    trial = {rem_q, quo_q[DATA_W-1]};
    diff  = trial - {1'b0, dv_q};
    fits  = (trial >= {1'b0, dv_q});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      dv_q  <= '0;
      quo_q <= '0;
    end else if (load) begin
      rem_q <= '0;
      dv_q  <= dv_mag;
      quo_q <= dd_mag;
    end else if (step) begin
      rem_q <= fits ? diff[DIV_W-1:0] : trial[DIV_W-1:0];
      quo_q <= {quo_q[DATA_W-2:0], fits};
    end
  end

  assign q_mag = quo_q;
endmodule

// File: rtl/hdiv_fix.sv
// Sign correction and flag derivation for the iterated result.
module hdiv_fix #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] q_mag,
  input  logic              q_neg,
  output logic [DATA_W-1:0] quot,
  output logic              is_zero,
  output logic              is_neg
);
  always_comb begin
    quot    = q_neg ? (~q_mag + 1'b1) : q_mag;
    is_zero = (quot == '0);
    is_neg  = quot[DATA_W-1];
  end
endmodule

// File: rtl/hdiv_top.sv
module hdiv_top #(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [DATA_W-1:0] req_dividend,
  input  logic [DATA_W-1:0] req_divisor,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_quot,
  output logic              res_wr,
  output logic              flag_z,
  output logic              flag_s,
  output logic              flag_ov
);
  import hdiv_pkg::*;

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(DATA_W - 1);
  localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  hdiv_state_e state_q;
  logic [CNT_W-1:0] cnt_q;
  logic neg_q;

  logic [DATA_W-1:0] dd_mag, q_mag, fix_quot;
  logic [DIV_W-1:0] dv_mag;
  logic q_neg, dv_zero, min_by_m1, fix_z, fix_s;
  logic accept, start_iter;
  logic unused_divisor_hi;

  assign unused_divisor_hi = ^req_divisor[DATA_W-1:DIV_W];

  assign req_ready  = (state_q == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign start_iter = accept && !dv_zero && !min_by_m1;

  hdiv_prep #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_prep (
    .dividend   (req_dividend),
    .divisor_lo (req_divisor[DIV_W-1:0]),
    .dd_mag     (dd_mag),
    .dv_mag     (dv_mag),
    .q_neg      (q_neg),
    .dv_zero    (dv_zero),
    .min_by_m1  (min_by_m1)
  );

  hdiv_iter #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_iter (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (start_iter),
    .step   (state_q == ST_ITER),
    .dd_mag (dd_mag),
    .dv_mag (dv_mag),
    .q_mag  (q_mag)
  );

  hdiv_fix #(.DATA_W(DATA_W)) u_fix (
    .q_mag   (q_mag),
    .q_neg   (neg_q),
    .quot    (fix_quot),
    .is_zero (fix_z),
    .is_neg  (fix_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      neg_q     <= 1'b0;
      res_valid <= 1'b0;
      res_quot  <= '0;
      res_wr    <= 1'b0;
      flag_z    <= 1'b0;
      flag_s    <= 1'b0;
      flag_ov   <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (dv_zero) begin
              res_valid <= 1'b1;
              res_wr    <= 1'b0;
              flag_ov   <= 1'b1;
            end else if (min_by_m1) begin
              res_valid <= 1'b1;
              res_wr    <= 1'b1;
              res_quot  <= MOST_NEG;
              flag_z    <= 1'b0;
              flag_s    <= 1'b1;
              flag_ov   <= 1'b1;
            end else begin
              state_q <= ST_ITER;
              cnt_q   <= '0;
              neg_q   <= q_neg;
            end
          end
        end
        ST_ITER: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST_STEP) state_q <= ST_FIX;
        end
        ST_FIX: begin
          state_q   <= ST_IDLE;
          res_valid <= 1'b1;
          res_wr    <= 1'b1;
          res_quot  <= fix_quot;
          flag_z    <= fix_z;
          flag_s    <= fix_s;
          flag_ov   <= 1'b0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hdiv_chk.sv
module hdiv_chk #(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [DATA_W-1:0] req_dividend,
  input logic [DATA_W-1:0] req_divisor,
  input logic              res_valid,
  input logic [DATA_W-1:0] res_quot,
  input logic              res_wr,
  input logic              flag_z,
  input logic              flag_s,
  input logic              flag_ov
);
  localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  assert_zero_div_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_divisor[DIV_W-1:0] == '0)
    |=> (res_valid && flag_ov && !res_wr && $stable(flag_z) && $stable(flag_s) && $stable(res_quot)));

  assert_min_by_m1_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_dividend == MOST_NEG && req_divisor[DIV_W-1:0] == '1)
    |=> (res_valid && flag_ov && res_wr && res_quot == MOST_NEG && flag_s && !flag_z));

  assert_busy_no_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> !res_valid);

  assert_ov_clear_writes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !flag_ov) |-> res_wr);

  assert_flags_track_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_wr) |-> ((flag_z == (res_quot == '0)) && (flag_s == res_quot[DATA_W-1])));

  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !req_valid) |=> !res_valid);

  assert_hold_between_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> ($stable(res_quot) && $stable(res_wr) && $stable(flag_z)
                    && $stable(flag_s) && $stable(flag_ov)));
endmodule

bind hdiv_top hdiv_chk #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_chk (.*);

// File: tb/hdiv_top_tb.sv
module hdiv_top_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [31:0] req_dividend = '0;
  logic [31:0] req_divisor = '0;
  logic req_ready, res_valid, res_wr, flag_z, flag_s, flag_ov;
  logic [31:0] res_quot;

  int checks = 0;
  int errors = 0;
  string cur_tag = "R3";
  bit finished = 0;

  hdiv_top u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_dividend(req_dividend), .req_divisor(req_divisor),
    .res_valid(res_valid), .res_quot(res_quot), .res_wr(res_wr),
    .flag_z(flag_z), .flag_s(flag_s), .flag_ov(flag_ov)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model
  int        m_cnt;
  bit        m_done;
  bit [31:0] m_quot, p_quot;
  bit        m_wr, m_z, m_s, m_ov;
  bit        p_z, p_s;
  string     m_tag, p_tag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_done = 0; m_quot = 0; m_wr = 0;
      m_z = 0; m_s = 0; m_ov = 0; m_tag = "R1";
    end else begin
      m_done = 0;
      if (m_cnt > 0) begin
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) begin
          m_done = 1; m_quot = p_quot; m_wr = 1;
          m_z = p_z; m_s = p_s; m_ov = 0; m_tag = p_tag;
        end
      end else if (req_valid) begin
        longint dd, dv, q;
        dd = longint'($signed(req_dividend));
        dv = longint'($signed(req_divisor[15:0]));
        if (dv == 0) begin
          m_done = 1; m_ov = 1; m_wr = 0; m_tag = "R7";
        end else if (dd == -64'sd2147483648 && dv == -1) begin
          m_done = 1; m_ov = 1; m_wr = 1; m_quot = 32'h8000_0000;
          m_z = 0; m_s = 1; m_tag = "R8";
        end else begin
          q = dd / dv;
          p_quot = q[31:0];
          p_z = (q == 0);
          p_s = p_quot[31];
          p_tag = cur_tag;
          m_cnt = 33;
        end
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison, away from the rising edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R4", {31'd0, req_ready}, {31'd0, m_cnt == 0});
      check(req_valid && !req_ready ? "R9" : "R4", {31'd0, res_valid}, {31'd0, m_done});
      if (res_valid) begin
        check(m_tag, res_quot, m_quot);
        check(m_tag == "R3" ? "R5" : m_tag, {31'd0, res_wr}, {31'd0, m_wr});
        check(m_tag == "R3" ? "R5" : m_tag, {31'd0, flag_ov}, {31'd0, m_ov});
        check(m_tag == "R3" ? "R6" : m_tag, {30'd0, flag_z, flag_s}, {30'd0, m_z, m_s});
      end else begin
        check("R10", res_quot, m_quot);
        check("R10", {28'd0, res_wr, flag_z, flag_s, flag_ov}, {28'd0, m_wr, m_z, m_s, m_ov});
      end
    end
  end

  task automatic run_div(logic [31:0] dd, logic [31:0] dv, string tag);
    @(negedge clk);
    cur_tag = tag;
    req_dividend = dd; req_divisor = dv; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!res_valid) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int seed;
    seed = 32'h1357_9bdf;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {31'd0, req_ready}, 32'd1);
    check("R1", {31'd0, res_valid}, 32'd0);
    check("R1", res_quot, 32'd0);
    check("R1", {28'd0, res_wr, flag_z, flag_s, flag_ov}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 sign combinations, truncation toward zero
    run_div(32'd100, 32'd7, "R3");
    run_div(-32'sd100, 32'd7, "R3");
    run_div(32'd100, -32'sd7, "R3");
    run_div(-32'sd100, -32'sd7, "R3");
    run_div(32'h8000_0000, 32'h0000_8000, "R3");
    run_div(32'h7FFF_FFFF, 32'h0000_7FFF, "R3");
    // R2 upper divisor bits ignored
    run_div(32'd30, 32'h1234_0003, "R2");
    run_div(32'd10, 32'h0000_FFFE, "R2");
    // R6 zero and sign flags
    run_div(32'd5, 32'd10, "R6");
    run_div(-32'sd7, 32'd1, "R6");
    // R5 most negative over one is not an overflow
    run_div(32'h8000_0000, 32'd1, "R5");
    // R7 zero divisor with non-zero upper bits
    run_div(32'd77, 32'hABCD_0000, "R7");
    run_div(32'd0, 32'd0, "R7");
    // R8 overflow corner, also with upper divisor bits set
    run_div(32'h8000_0000, 32'hFFFF_FFFF, "R8");
    run_div(32'h8000_0000, 32'h1234_FFFF, "R8");

    // R9 requests offered while busy are ignored
    @(negedge clk);
    cur_tag = "R9";
    req_dividend = 32'd1000; req_divisor = 32'd3; req_valid = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      req_dividend = 32'd55 + i; req_divisor = 32'd0;
      @(negedge clk);
    end
    req_valid = 1'b0;
    while (!res_valid) @(negedge clk);
    check("R9", res_quot, 32'd333);
    repeat (3) @(negedge clk);

    // Pseudo-random operands
    for (int i = 0; i < 20; i++) begin
      logic [31:0] a, b;
      seed = seed * 1103515245 + 12345; a = seed;
      seed = seed * 1103515245 + 12345; b = seed;
      run_div(a, b, "R3");
    end

    finished = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    finished = 1;
    errors++;
    $display("FAIL R4: watchdog expired, actual hung expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule